// File: doc/BRIEF.md
# Word-Wide Shift Register with Finite-Field Feedback

This block is a sixteen-deep shift register whose stages are 32-bit words. It is built as the linear half of a word-oriented stream generator. Each time it advances, it drops the oldest word (stage 0), moves every other word down one place, and writes a freshly computed feedback word into the top stage (stage 15). The feedback mixes whole-word shifts and XORs with two byte-to-word maps over GF(2^8), using the field constant 0xA9. The first map multiplies by a fixed element and is applied to the most significant byte of stage 0. The second divides by that element and is applied to the least significant byte of stage 11.

There are two advance modes. In the setup mode, a 32-bit word supplied from outside (normally the output of a companion nonlinear stage) is XORed into the feedback. In the running mode, that input is ignored. The surrounding logic loads all sixteen stages at once, chooses the mode, strobes an advance, and reads stages 0, 5 and 15 from the tap outputs. Both field maps are reduced at elaboration time to fixed XOR matrices, so one advance completes in one clock.

Top module: `gf_word_lfsr`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all sixteen stages to zero. It wins over a load and over an advance in the same cycle.
- R2: With `loadEn` high at a rising edge, stage i takes `loadData[32*i+31 : 32*i]` for every i from 0 to 15.
- R3: When `loadEn` and `advance` are both high in the same cycle, the load takes effect and no advance happens.
- R4: On an advance (`advance` high, `loadEn` low), stage i takes the previous value of stage i+1 for every i from 0 to 14.
- R5: On an advance in running mode, stage 15 takes the value (s0 << 8) ^ MA(s0[31:24]) ^ s2 ^ (s11 >> 8) ^ DA(s11[7:0]). Both shifts are logical and fill with zeros.
- R6: Let X(v) be v shifted left one bit within 8 bits, XORed with 0xA9 when bit 7 of v was set before the shift, and let X^n be X applied n times. MA(c) is the word {X^23(c), X^245(c), X^48(c), X^239(c)}, with the most significant byte first.
- R7: DA(c) is the word {X^16(c), X^39(c), X^6(c), X^64(c)}, with the most significant byte first and X as in R6.
- R8: On an advance with `initMode` high, the word written into stage 15 is the R5 value XORed with `fIn`.
- R9: On an advance with `initMode` low, `fIn` has no effect on any stage.
- R10: With neither `loadEn` nor `advance` high, every stage keeps its value whatever `initMode` and `fIn` do.
- R11: `tapLow`, `tapMid` and `tapHigh` show stages 0, 5 and 15 in the same cycle that the register updates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high; clears every stage |
| loadEn | input | 1 | Load all stages from `loadData` |
| loadData | input | 512 | Sixteen packed words; stage i sits at bits 32*i+31 down to 32*i |
| advance | input | 1 | Shift by one word and insert the feedback word |
| initMode | input | 1 | 1: XOR `fIn` into the feedback; 0: ignore `fIn` |
| fIn | input | 32 | External word mixed in during setup-mode advances |
| tapLow | output | 32 | Stage 0 |
| tapMid | output | 32 | Stage 5 |
| tapHigh | output | 32 | Stage 15 |

## Verification
The field maps are tested in isolation by loading a register that is all zero except for one byte: either the top byte of stage 0 or the bottom byte of stage 11. One running-mode advance then places the bare MA or DA image in stage 15. The byte values 0x01, 0x80, 0xA9 and 0xFF cover the cases where the reduction constant is never applied and where it is applied on the first shift. Long runs from dense pseudo-random loads, in both modes and with `fIn` driven nonzero, separate the shift-and-XOR terms from one another. In running mode, a nonzero `fIn` must leave the result unchanged, which shows the mode select is honoured. Directed cycles check load against advance, reset against load, and idle cycles with changing `fIn`, which show the priority order and the hold behaviour.

// File: rtl/gf_lfsr_pkg.sv
package gf_lfsr_pkg;

  localparam int WORD_W = 32;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] FIELD_POLY = 8'hA9;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
    logic mixExt;
  } lfsrCmd_t;

  // Repeated doubling in GF(2^8) with the given reduction byte
  function automatic logic [BYTE_W-1:0] mulxRep(input logic [BYTE_W-1:0] v,
                                                input int unsigned n,
                                                input logic [BYTE_W-1:0] c);
    logic [BYTE_W-1:0] r;
    r = v;
    for (int unsigned k = 0; k < n; k++) begin
      if (r[BYTE_W-1]) r = {r[BYTE_W-2:0], 1'b0} ^ c;
      else             r = {r[BYTE_W-2:0], 1'b0};
    end
    return r;
  endfunction

  // Full word image of one byte under the multiply or divide map
  function automatic logic [WORD_W-1:0] alphaImage(input logic [BYTE_W-1:0] b,
                                                   input bit divide);
    logic [WORD_W-1:0] w;
    if (divide)
      w = {mulxRep(b, 16, FIELD_POLY), mulxRep(b, 39, FIELD_POLY),
           mulxRep(b, 6, FIELD_POLY),  mulxRep(b, 64, FIELD_POLY)};
    else
      w = {mulxRep(b, 23, FIELD_POLY),  mulxRep(b, 245, FIELD_POLY),
           mulxRep(b, 48, FIELD_POLY),  mulxRep(b, 239, FIELD_POLY)};
    return w;
  endfunction

  // Columns of the GF(2) matrix: image of each single-bit byte
  function automatic logic [BYTE_W-1:0][WORD_W-1:0] alphaBasis(input bit divide);
    logic [BYTE_W-1:0][WORD_W-1:0] cols;
    for (int k = 0; k < BYTE_W; k++) begin
      cols[k] = alphaImage(BYTE_W'(1) << k, divide);
    end
    return cols;
  endfunction

endpackage

// File: rtl/gf_byte_map.sv
module gf_byte_map
  import gf_lfsr_pkg::*;
#(
  parameter bit DIVIDE = 1'b0
) (
  input  logic [BYTE_W-1:0] byteIn,
  output logic [WORD_W-1:0] wordOut
);

  // The map is linear, so it is a fixed XOR matrix built at elaboration
  localparam logic [BYTE_W-1:0][WORD_W-1:0] BASIS = alphaBasis(DIVIDE);

  logic [BYTE_W-1:0][WORD_W-1:0] gated;

  genvar k;
  generate
    for (k = 0; k < BYTE_W; k++) begin : g_col
      assign gated[k] = byteIn[k] ? BASIS[k] : '0;
    end
  endgenerate

  always_comb begin
    wordOut = '0;
    for (int j = 0; j < BYTE_W; j++) begin
      wordOut = wordOut ^ gated[j];
    end
  end

endmodule

// File: rtl/gf_lfsr_ctrl.sv
module gf_lfsr_ctrl
  import gf_lfsr_pkg::*;
(
  input  logic     rst,
  input  logic     loadEn,
  input  logic     advance,
  input  logic     initMode,
  output lfsrCmd_t cmd
);

  // Priority: reset, then load, then advance
  always_comb begin
    cmd.clear  = rst;
    cmd.load   = !rst && loadEn;
    cmd.step   = !rst && !loadEn && advance;
    cmd.mixExt = initMode;
  end

endmodule

// File: rtl/gf_lfsr_dp.sv
module gf_lfsr_dp
  import gf_lfsr_pkg::*;
#(
  parameter int NUM_STAGES = 16,
  parameter int TAP_NEAR   = 2,
  parameter int TAP_FAR    = 11
) (
  input  logic                                clk,
  input  lfsrCmd_t                            cmd,
  input  logic [NUM_STAGES*WORD_W-1:0]        loadData,
  input  logic [WORD_W-1:0]                   fIn,
  output logic [NUM_STAGES-1:0][WORD_W-1:0]   stageQ
);

  localparam int TOP = NUM_STAGES - 1;

  logic [WORD_W-1:0] mulWord;
  logic [WORD_W-1:0] divWord;
  logic [WORD_W-1:0] feedback;

  gf_byte_map #(.DIVIDE(1'b0)) u_mulMap (
    .byteIn (stageQ[0][WORD_W-1 -: BYTE_W]),
    .wordOut(mulWord)
  );

  gf_byte_map #(.DIVIDE(1'b1)) u_divMap (
    .byteIn (stageQ[TAP_FAR][BYTE_W-1:0]),
    .wordOut(divWord)
  );

  always_comb begin
    feedback = {stageQ[0][WORD_W-BYTE_W-1:0], {BYTE_W{1'b0}}}
             ^ mulWord
             ^ stageQ[TAP_NEAR]
             ^ {{BYTE_W{1'b0}}, stageQ[TAP_FAR][WORD_W-1:BYTE_W]}
             ^ divWord;
    if (cmd.mixExt) feedback = feedback ^ fIn;
  end

  always_ff @(posedge clk) begin
    if (cmd.clear) begin
      stageQ <= '0;
    end else if (cmd.load) begin
      for (int i = 0; i < NUM_STAGES; i++) begin
        stageQ[i] <= loadData[i*WORD_W +: WORD_W];
      end
    end else if (cmd.step) begin
      for (int i = 0; i < TOP; i++) begin
        stageQ[i] <= stageQ[i+1];
      end
      stageQ[TOP] <= feedback;
    end
  end

endmodule

// File: rtl/gf_word_lfsr.sv
module gf_word_lfsr
  import gf_lfsr_pkg::*;
#(
  parameter int NUM_STAGES = 16,
  parameter int TAP_MID    = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         loadEn,
  input  logic [NUM_STAGES*WORD_W-1:0] loadData,
  input  logic                         advance,
  input  logic                         initMode,
  input  logic [WORD_W-1:0]            fIn,
  output logic [WORD_W-1:0]            tapLow,
  output logic [WORD_W-1:0]            tapMid,
  output logic [WORD_W-1:0]            tapHigh
);

  lfsrCmd_t                          cmd;
  logic [NUM_STAGES-1:0][WORD_W-1:0] stageQ;

  gf_lfsr_ctrl u_ctrl (
    .rst     (rst),
    .loadEn  (loadEn),
    .advance (advance),
    .initMode(initMode),
    .cmd     (cmd)
  );

  gf_lfsr_dp #(
    .NUM_STAGES(NUM_STAGES),
    .TAP_NEAR  (2),
    .TAP_FAR   (11)
  ) u_dp (
    .clk     (clk),
    .cmd     (cmd),
    .loadData(loadData),
    .fIn     (fIn),
    .stageQ  (stageQ)
  );

  assign tapLow  = stageQ[0];
  assign tapMid  = stageQ[TAP_MID];
  assign tapHigh = stageQ[NUM_STAGES-1];

endmodule

// File: rtl/gf_word_lfsr_chk.sv
module gf_word_lfsr_chk
  import gf_lfsr_pkg::*;
#(
  parameter int NUM_STAGES = 16
) (
  input logic                              clk,
  input logic                              rst,
  input logic                              loadEn,
  input logic                              advance,
  input logic [NUM_STAGES*WORD_W-1:0]      loadData,
  input logic [NUM_STAGES-1:0][WORD_W-1:0] stages
);

  // R1: reset leaves every stage at zero on the next cycle
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (stages == '0));

  // R2 and R3: a load wins over an advance and copies the whole vector
  a_r3_load_wins: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> (stages == $past(loadData)));

  // R4: an advance moves every lower stage down by one
  a_r4_shift_down: assert property (@(posedge clk) disable iff (rst)
    (advance && !loadEn) |=>
      (stages[NUM_STAGES-2:0] == $past(stages[NUM_STAGES-1:1])));

  // R10: idle cycles keep the register unchanged
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!advance && !loadEn) |=> $stable(stages));

endmodule

bind gf_word_lfsr gf_word_lfsr_chk #(.NUM_STAGES(NUM_STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .loadEn  (loadEn),
  .advance (advance),
  .loadData(loadData),
  .stages  (u_dp.stageQ)
);

// File: tb/gf_word_lfsr_bench.sv
module gf_word_lfsr_bench;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            loadEn = 1'b0;
  logic [N*32-1:0] loadData = '0;
  logic            advance = 1'b0;
  logic            initMode = 1'b0;
  logic [31:0]     fIn = '0;
  logic [31:0]     tapLow, tapMid, tapHigh;

  int testCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  logic [31:0] mdl [N];

  always #(CLK_PERIOD/2) clk = ~clk;

  gf_word_lfsr u_gf_word_lfsr (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadData(loadData),
    .advance(advance), .initMode(initMode), .fIn(fIn),
    .tapLow(tapLow), .tapMid(tapMid), .tapHigh(tapHigh)
  );

  typedef struct packed {
    logic [31:0] seed;
    logic        setup;
    logic [31:0] fWord;
    logic [7:0]  steps;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{seed: 32'h0123_4567, setup: 1'b0, fWord: 32'h0000_0000, steps: 8'd20},
    '{seed: 32'hDEAD_BEEF, setup: 1'b0, fWord: 32'hFFFF_FFFF, steps: 8'd24},
    '{seed: 32'h8000_0001, setup: 1'b1, fWord: 32'h0000_0000, steps: 8'd18},
    '{seed: 32'hA5A5_5A5A, setup: 1'b1, fWord: 32'h1357_9BDF, steps: 8'd32},
    '{seed: 32'hFFFF_FFFF, setup: 1'b1, fWord: 32'hC3C3_3C3C, steps: 8'd20},
    '{seed: 32'h0000_0000, setup: 1'b0, fWord: 32'h7777_8888, steps: 8'd17}
  };

  // Independent model of the field doubling
  function automatic logic [7:0] dbl(input logic [7:0] v, input int n);
    logic [7:0] r = v;
    int cnt = n;
    while (cnt > 0) begin
      r = (r << 1) ^ (r[7] ? 8'hA9 : 8'h00);
      cnt--;
    end
    return r;
  endfunction

  function automatic logic [31:0] refMul(input logic [7:0] c);
    return {dbl(c, 23), dbl(c, 245), dbl(c, 48), dbl(c, 239)};
  endfunction

  function automatic logic [31:0] refDiv(input logic [7:0] c);
    return {dbl(c, 16), dbl(c, 39), dbl(c, 6), dbl(c, 64)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic checkTaps(input string req);
    check({req, " s0"},  tapLow,  mdl[0]);
    check({req, " s5"},  tapMid,  mdl[5]);
    check({req, " s15"}, tapHigh, mdl[15]);
  endtask

  task automatic modelStep(input bit setup, input logic [31:0] f);
    logic [31:0] v;
    v = (mdl[0] << 8) ^ refMul(mdl[0][31:24]) ^ mdl[2] ^ (mdl[11] >> 8)
      ^ refDiv(mdl[11][7:0]);
    if (setup) v ^= f;
    for (int i = 0; i < N-1; i++) mdl[i] = mdl[i+1];
    mdl[N-1] = v;
  endtask

  // All tasks start and end just after a falling edge
  task automatic loadWords(input logic [31:0] w [N]);
    for (int i = 0; i < N; i++) loadData[i*32 +: 32] = w[i];
    loadEn = 1'b1;
    @(negedge clk);
    loadEn = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = w[i];
  endtask

  task automatic loadSeed(input logic [31:0] seed);
    logic [31:0] w [N];
    for (int i = 0; i < N; i++) w[i] = seed ^ (32'h9E37_79B9 * (i + 1)) ^ {i[7:0], 24'h0};
    loadWords(w);
  endtask

  task automatic stepOnce(input bit setup, input logic [31:0] f);
    advance = 1'b1; initMode = setup; fIn = f;
    @(negedge clk);
    advance = 1'b0; fIn = 32'h5A5A_0F0F;
    modelStep(setup, f);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [31:0] w [N];
    logic [7:0] bytesUnderTest [4];
    bytesUnderTest = '{8'h01, 8'h80, 8'hA9, 8'hFF};

    // R1: reset state
    repeat (2) @(negedge clk);
    for (int i = 0; i < N; i++) mdl[i] = '0;
    checkTaps("R1 reset");
    rst = 1'b0;

    // R2, R4, R5, R8, R9, R11: table walk
    for (int t = 0; t < 6; t++) begin
      loadSeed(VECS[t].seed);
      checkTaps("R2 load");
      for (int s = 0; s < int'(VECS[t].steps); s++) begin
        stepOnce(VECS[t].setup, VECS[t].fWord ^ (s * 32'h0101_0101));
        if (VECS[t].setup) checkTaps("R8 setup advance");
        else               checkTaps("R9 R5 running advance");
      end
    end

    // R6: multiply map through stage 0 top byte
    foreach (bytesUnderTest[b]) begin
      for (int i = 0; i < N; i++) w[i] = '0;
      w[0] = {bytesUnderTest[b], 24'h0};
      loadWords(w);
      stepOnce(1'b0, 32'hFFFF_FFFF);
      check("R6 mul map", tapHigh, refMul(bytesUnderTest[b]));
      check("R4 s0 after step", tapLow, 32'h0);
    end

    // R7: divide map through stage 11 bottom byte
    foreach (bytesUnderTest[b]) begin
      for (int i = 0; i < N; i++) w[i] = '0;
      w[11] = {24'h0, bytesUnderTest[b]};
      loadWords(w);
      stepOnce(1'b0, 32'h1234_5678);
      check("R7 div map", tapHigh, refDiv(bytesUnderTest[b]));
    end

    // R8: pure external injection on an all-zero register
    for (int i = 0; i < N; i++) w[i] = '0;
    loadWords(w);
    stepOnce(1'b1, 32'hCAFE_F00D);
    check("R8 inject only", tapHigh, 32'hCAFE_F00D);

    // R3: load wins over advance
    loadSeed(32'h2468_ACE0);
    for (int i = 0; i < N; i++) w[i] = 32'h1111_1111 * (i + 1);
    for (int i = 0; i < N; i++) loadData[i*32 +: 32] = w[i];
    loadEn = 1'b1; advance = 1'b1; initMode = 1'b1; fIn = 32'hFFFF_0000;
    @(negedge clk);
    loadEn = 1'b0; advance = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = w[i];
    checkTaps("R3 load priority");

    // R10: idle cycles with changing inputs
    for (int k = 0; k < 3; k++) begin
      initMode = k[0]; fIn = 32'h0F0F_0F0F << k;
      @(negedge clk);
      checkTaps("R10 idle hold");
    end

    // R1: reset wins over load and advance
    loadEn = 1'b1; advance = 1'b1; rst = 1'b1;
    @(negedge clk);
    loadEn = 1'b0; advance = 1'b0; rst = 1'b0;
    for (int i = 0; i < N; i++) mdl[i] = '0;
    checkTaps("R1 reset priority");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule